// File: doc/BRIEF.md
# Descriptor-Driven Sector DMA Engine

This block moves sector data between a storage drive and system memory without processor involvement. Software builds a table of region descriptors in memory. Each descriptor is two 32-bit words: a buffer address, then a size word whose top bit flags the final entry. Software loads the table base into the pointer register and sets the start bit. The engine then reads descriptors one at a time and streams 16-bit words between the drive and the described buffers. The direction comes from the command register.

The drive side is a word handshake. The drive presents a total byte count and raises its request line while it can supply or accept a word. The engine answers with one acknowledge pulse per word moved. Memory is reached through a single-beat request/grant port that carries a 32-bit lane. Each 16-bit word sits in the half chosen by address bit 1.

At the end, the active and interrupt bits show how the table length compared with the drive transfer:
- table exactly as long as the transfer: active clear, interrupt set;
- table too short: active clear, no interrupt;
- table too long: both active and interrupt set;
- host cancel or memory fault: this outcome is recorded as well.

Top module: `bmdma_engine`

## Requirements
- R1: After reset the command, status and pointer registers read 0, irq_o is low and no memory request is issued.
- R2: Registers sit at byte offsets 0 (command: bit 0 start, bit 3 direction), 2 (status: bit 0 active, bit 1 error, bit 2 interrupt) and 4 (table pointer, bits 1:0 read as 0). Command and pointer read back what was written. Writing the command without the start bit leaves the status at 0.
- R3: Writing start=1 while the stored start bit is 0 sets active and latches the pointer. Descriptors are read in table order, with the address word at the pointer and the size word at pointer+4. The next descriptor follows 8 bytes later.
- R4: When the table total equals the drive byte count, the transfer ends with status 0x04 and irq_o high.
- R5: When the table ends before the drive byte count is reached, the engine stops and the status is 0x00. Exactly the table's bytes are moved.
- R6: When the drive byte count is reached with table space left, the status is 0x05. No further words move.
- R7: Writing the command with start=0 while active stops the engine, clears active and sets interrupt. Long-table completion followed by this write gives 0x04. A stalled transfer cancelled this way moves no more words.
- R8: Writing 1 to status bit 2 or bit 1 clears that bit. Writing 0 to the status register changes nothing.
- R9: With direction=1, drive words are written to memory. With direction=0, memory words are sent to the drive. The 16-bit word travels in lane bits 31:16 when address bit 1 is set, otherwise in bits 15:0.
- R10: A descriptor size of 0 in bits 15:0 means 65536 bytes. Bit 0 of both the size and the buffer address is ignored (treated as 0).
- R11: A memory port error ends the transfer with status 0x06 (error and interrupt set, active clear) and irq_o high.
- R12: An issued memory request keeps its address stable and stays asserted until it is granted. This assumes the drive holds its request until acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| irq_o | output | 1 | Interrupt, mirrors status bit 2 |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory request is a write |
| mem_addr_o | output | 32 | Memory byte address |
| mem_wdata_o | output | 32 | Memory write data (word in both halves) |
| mem_gnt_i | input | 1 | Memory grant, completes the request |
| mem_err_i | input | 1 | Error on the granted request |
| mem_rdata_i | input | 32 | Read data, valid with the grant |
| drv_bytes_i | input | 20 | Drive transfer length in bytes, sampled at start |
| drv_req_i | input | 1 | Drive ready to supply or accept a word |
| drv_rdata_i | input | 16 | Word from the drive |
| drv_ack_o | output | 1 | One word moved this cycle |
| drv_wdata_o | output | 16 | Word to the drive, valid with drv_ack_o |

## Verification
Several rules are checked by assertions on every cycle:
- an ungranted memory request holding its address;
- buffer addresses staying word aligned;
- a drive acknowledge only ever coinciding with a clean grant;
- the flag updates that follow a fault or a host cancel.

Other behaviour can only be shown by the bench scenarios:
- the outcome encoding across short, exact and long tables;
- the 64 KiB reading of a zero size;
- the ordering across multi-entry tables;
- the data landing in the correct buffer lanes in both directions.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;
  localparam logic [2:0] REG_CMD = 3'd0;
  localparam logic [2:0] REG_STS = 3'd2;
  localparam logic [2:0] REG_PTR = 3'd4;

  typedef enum logic [2:0] {
    EV_NONE,
    EV_EXACT,
    EV_SHORT,
    EV_LONG,
    EV_FAULT
  } evt_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DADDR,
    ST_DSIZE,
    ST_MOVE,
    ST_HOLD
  } state_e;
endpackage

// File: rtl/bmdma_regs.sv
module bmdma_regs
  import bmdma_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [2:0]    reg_addr_i,
  input  logic [31:0]   reg_wdata_i,
  output logic [31:0]   reg_rdata_o,
  input  evt_e          evt_i,
  output logic          go_o,
  output logic          stop_o,
  output logic          dir_o,
  output logic [AW-1:0] ptr_o,
  output logic          active_o,
  output logic          irq_o
);
  logic          start_q, dir_q, active_q, err_q, intr_q;
  logic [AW-1:0] ptr_q;
  logic          cmd_wr;

  assign cmd_wr = reg_we_i && (reg_addr_i == REG_CMD);
  assign go_o   = cmd_wr && reg_wdata_i[0] && !start_q;
  assign stop_o = cmd_wr && !reg_wdata_i[0] && active_q;
  assign dir_o  = reg_wdata_i[3];
  assign ptr_o  = ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q  <= 1'b0;
      dir_q    <= 1'b0;
      active_q <= 1'b0;
      err_q    <= 1'b0;
      intr_q   <= 1'b0;
      ptr_q    <= '0;
    end else begin
      if (reg_we_i && reg_addr_i == REG_STS) begin
        if (reg_wdata_i[2]) intr_q <= 1'b0;
        if (reg_wdata_i[1]) err_q  <= 1'b0;
      end
      unique case (evt_i)
        EV_EXACT: begin active_q <= 1'b0; intr_q <= 1'b1; end
        EV_SHORT: active_q <= 1'b0;
        EV_LONG:  intr_q <= 1'b1;
        EV_FAULT: begin active_q <= 1'b0; err_q <= 1'b1; intr_q <= 1'b1; end
        default: ;
      endcase
      if (go_o) active_q <= 1'b1;
      if (stop_o) begin
        active_q <= 1'b0;
        intr_q   <= 1'b1;
      end
      if (cmd_wr) begin
        start_q <= reg_wdata_i[0];
        dir_q   <= reg_wdata_i[3];
      end
      if (reg_we_i && reg_addr_i == REG_PTR) ptr_q <= {reg_wdata_i[AW-1:2], 2'b00};
    end
  end

  always_comb begin
    unique case (reg_addr_i)
      REG_CMD: reg_rdata_o = {28'd0, dir_q, 2'b00, start_q};
      REG_STS: reg_rdata_o = {29'd0, intr_q, err_q, active_q};
      REG_PTR: reg_rdata_o = 32'(ptr_q);
      default: reg_rdata_o = '0;
    endcase
  end

  assign active_o = active_q;
  assign irq_o    = intr_q;

  // R11
  fault_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i == EV_FAULT) |=> (err_q && intr_q && !active_q));

  // R7
  cancel_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_o |=> (!active_q && intr_q));
endmodule

// File: rtl/bmdma_seq.sv
module bmdma_seq
  import bmdma_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 16,
  parameter int LEN_W = 20,
  parameter int SZ_W  = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  input  logic          stop_i,
  input  logic          dir_i,
  input  logic [AW-1:0] ptr_i,
  input  logic [LEN_W-1:0] drv_bytes_i,
  input  logic          drv_req_i,
  input  logic [DW-1:0] drv_rdata_i,
  output logic          drv_ack_o,
  output logic [DW-1:0] drv_wdata_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [2*DW-1:0] mem_wdata_o,
  input  logic          mem_gnt_i,
  input  logic          mem_err_i,
  input  logic [2*DW-1:0] mem_rdata_i,
  output evt_e          evt_o
);
  localparam int MW     = 2 * DW;
  localparam int STEP   = DW / 8;
  localparam int LANE_B = $clog2(STEP);
  localparam int SEG_W  = SZ_W + 1;

  state_e            state_q;
  logic [AW-1:0]     desc_q, buf_q;
  logic [SEG_W-1:0]  seg_q;
  logic [LEN_W-1:0]  left_q;
  logic              last_q, dir_q;
  logic              seg_zero, left_zero, move_ok, done, fault;
  logic [SZ_W-1:0]   size_w;

  assign seg_zero  = (seg_q == '0);
  assign left_zero = (left_q == '0);
  assign move_ok   = (state_q == ST_MOVE) && !seg_zero && !left_zero;
  assign size_w    = {mem_rdata_i[SZ_W-1:LANE_B], {LANE_B{1'b0}}};

  assign mem_req_o = (state_q == ST_DADDR) || (state_q == ST_DSIZE) || (move_ok && drv_req_i);
  assign mem_we_o  = (state_q == ST_MOVE) && dir_q;
  assign done      = mem_req_o && mem_gnt_i;
  assign fault     = done && mem_err_i;
  assign drv_ack_o = done && !mem_err_i && (state_q == ST_MOVE);

  always_comb begin
    unique case (state_q)
      ST_DADDR: mem_addr_o = desc_q;
      ST_DSIZE: mem_addr_o = desc_q + AW'(4);
      default:  mem_addr_o = buf_q;
    endcase
  end

  assign mem_wdata_o = {drv_rdata_i, drv_rdata_i};
  assign drv_wdata_o = buf_q[LANE_B] ? mem_rdata_i[MW-1:DW] : mem_rdata_i[DW-1:0];

  always_comb begin
    evt_o = EV_NONE;
    if (fault) evt_o = EV_FAULT;
    else if (state_q == ST_MOVE && (seg_zero || left_zero)) begin
      if (left_zero)   evt_o = (seg_zero && last_q) ? EV_EXACT : EV_LONG;
      else if (last_q) evt_o = EV_SHORT;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      desc_q  <= '0;
      buf_q   <= '0;
      seg_q   <= '0;
      left_q  <= '0;
      last_q  <= 1'b0;
      dir_q   <= 1'b0;
    end else if (stop_i) begin
      state_q <= ST_IDLE;
    end else if (go_i) begin
      state_q <= ST_DADDR;
      desc_q  <= ptr_i;
      left_q  <= {drv_bytes_i[LEN_W-1:LANE_B], {LANE_B{1'b0}}};
      dir_q   <= dir_i;
    end else if (fault) begin
      state_q <= ST_IDLE;
    end else begin
      unique case (state_q)
        ST_DADDR: if (done) begin
          buf_q   <= {mem_rdata_i[AW-1:LANE_B], {LANE_B{1'b0}}};
          state_q <= ST_DSIZE;
        end
        ST_DSIZE: if (done) begin
          seg_q   <= (size_w == '0) ? SEG_W'(1) << SZ_W : SEG_W'(size_w);
          last_q  <= mem_rdata_i[MW-1];
          desc_q  <= desc_q + AW'(8);
          state_q <= ST_MOVE;
        end
        ST_MOVE: begin
          if (seg_zero || left_zero) begin
            if (left_zero)   state_q <= (seg_zero && last_q) ? ST_IDLE : ST_HOLD;
            else if (last_q) state_q <= ST_IDLE;
            else             state_q <= ST_DADDR;
          end else if (done) begin
            buf_q  <= buf_q + AW'(STEP);
            seg_q  <= seg_q - SEG_W'(STEP);
            left_q <= left_q - LEN_W'(STEP);
          end
        end
        default: ;
      endcase
    end
  end

  // R12
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_gnt_i && !stop_i && drv_req_i) |=> (mem_req_o && $stable(mem_addr_o)));

  // R10
  buf_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && state_q == ST_MOVE) |-> (mem_addr_o[LANE_B-1:0] == '0));
endmodule

// File: rtl/bmdma_engine.sv
module bmdma_engine
  import bmdma_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 16,
  parameter int LEN_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [2:0]       reg_addr_i,
  input  logic [31:0]      reg_wdata_i,
  output logic [31:0]      reg_rdata_o,
  output logic             irq_o,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [2*DW-1:0]  mem_wdata_o,
  input  logic             mem_gnt_i,
  input  logic             mem_err_i,
  input  logic [2*DW-1:0]  mem_rdata_i,
  input  logic [LEN_W-1:0] drv_bytes_i,
  input  logic             drv_req_i,
  input  logic [DW-1:0]    drv_rdata_i,
  output logic             drv_ack_o,
  output logic [DW-1:0]    drv_wdata_o
);
  evt_e          evt;
  logic          go, stop, dir, active;
  logic [AW-1:0] ptr;

  bmdma_regs #(.AW(AW)) regs_i (
    .clk_i, .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .evt_i(evt), .go_o(go), .stop_o(stop), .dir_o(dir), .ptr_o(ptr),
    .active_o(active), .irq_o
  );

  bmdma_seq #(.AW(AW), .DW(DW), .LEN_W(LEN_W)) seq_i (
    .clk_i, .rst_ni, .go_i(go), .stop_i(stop), .dir_i(dir), .ptr_i(ptr),
    .drv_bytes_i, .drv_req_i, .drv_rdata_i, .drv_ack_o, .drv_wdata_o,
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o,
    .mem_gnt_i, .mem_err_i, .mem_rdata_i, .evt_o(evt)
  );

  // R3
  req_when_active_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> active);

  // R9
  ack_clean_gnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drv_ack_o |-> (mem_req_o && mem_gnt_i && !mem_err_i));
endmodule

// File: tb/bmdma_engine_tb_top.sv
module bmdma_engine_tb_top;
  localparam int TBL  = 32'h100;
  localparam int BUF0 = 32'h1000;
  localparam int BUF1 = 32'h2000;

  typedef struct packed {
    logic        dir;
    logic        two;
    logic [15:0] sz0;
    logic [15:0] sz1;
    logic [19:0] nbytes;
    logic [2:0]  exp_st;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 16'h0200, 16'h0000, 20'd512, 3'h4},
    '{1'b1, 1'b0, 16'h0010, 16'h0000, 20'd512, 3'h0},
    '{1'b1, 1'b0, 16'h1000, 16'h0000, 20'd512, 3'h5},
    '{1'b0, 1'b1, 16'h0100, 16'h0100, 20'd512, 3'h4},
    '{1'b1, 1'b0, 16'h0000, 16'h0000, 20'd512, 3'h5},
    '{1'b0, 1'b1, 16'h0010, 16'h0010, 20'd64,  3'h0},
    '{1'b1, 1'b1, 16'h0080, 16'h0080, 20'd256, 3'h4}
  };

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic reg_we_i = 1'b0;
  logic [2:0] reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0, reg_rdata_o;
  logic irq_o, mem_req_o, mem_we_o, drv_ack_o;
  logic [31:0] mem_addr_o, mem_wdata_o;
  logic mem_gnt_i = 1'b0, mem_err_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;
  logic [19:0] drv_bytes_i = '0;
  logic drv_req_i = 1'b0;
  logic [15:0] drv_rdata_i, drv_wdata_o;

  bmdma_engine dut_i (.*);

  always #10 clk_i = ~clk_i;

  logic [31:0] mem_q [4096];
  logic [15:0] cap_q [4096];
  int   drv_k = 0, ack_seen = 0;
  logic drv_en = 1'b0;
  logic [7:0] lfsr = 8'h5B;
  logic [31:0] err_addr = 32'hFFFF_FFFF;
  int   setup_req = 0, setup_ack = 0;
  logic t_two = 1'b0;
  logic [15:0] t_sz0 = '0, t_sz1 = '0;
  logic p_req = 1'b0, p_gnt = 1'b0;
  logic [31:0] p_addr = '0;
  int   hold_viol = 0;
  int   n_chk = 0, n_fail = 0;

  assign drv_rdata_i = 16'h5A00 ^ drv_k[15:0];

  always @(posedge clk_i) begin
    #2;
    drv_k = ack_seen;
    drv_req_i = drv_en;
    #1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    mem_gnt_i = mem_req_o && (lfsr[1:0] != 2'b00);
    mem_err_i = mem_gnt_i && (mem_addr_o == err_addr);
    mem_rdata_i = mem_q[mem_addr_o[13:2]];
  end

  always @(negedge clk_i) begin
    if (setup_req != setup_ack) begin
      for (int i = 0; i < 4096; i++)
        mem_q[i] = {16'(i*4+2) ^ 16'h3C3C, 16'(i*4) ^ 16'h3C3C};
      mem_q[TBL/4]   = BUF0 | 1;
      mem_q[TBL/4+1] = {!t_two, 15'd0, t_sz0};
      mem_q[TBL/4+2] = BUF1;
      mem_q[TBL/4+3] = {1'b1, 15'd0, t_sz1};
      setup_ack = setup_req;
    end
    if (mem_req_o && mem_gnt_i && !mem_err_i && mem_we_o) begin
      if (mem_addr_o[1]) mem_q[mem_addr_o[13:2]][31:16] = mem_wdata_o[31:16];
      else               mem_q[mem_addr_o[13:2]][15:0]  = mem_wdata_o[15:0];
    end
    if (drv_ack_o) begin
      cap_q[ack_seen % 4096] = drv_wdata_o;
      ack_seen = ack_seen + 1;
    end
    if (rst_ni && p_req && !p_gnt && (!mem_req_o || mem_addr_o != p_addr)) hold_viol++;
    p_req = mem_req_o; p_gnt = mem_gnt_i; p_addr = mem_addr_o;
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk_i); reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i); reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk_i); reg_addr_i = a; #1; d = reg_rdata_o;
  endtask

  task automatic setup(input logic two, input logic [15:0] s0, input logic [15:0] s1);
    t_two = two; t_sz0 = s0; t_sz1 = s1;
    setup_req++;
    repeat (2) @(negedge clk_i);
  endtask

  task automatic wait_done(output logic [31:0] st);
    for (int i = 0; i < 20000; i++) begin
      rd(3'd2, st);
      if (!st[0] || st[2]) break;
    end
    repeat (4) @(negedge clk_i);
    rd(3'd2, st);
  endtask

  function automatic logic [15:0] mhalf(input int a);
    return a[1] ? mem_q[a[13:2]][31:16] : mem_q[a[13:2]][15:0];
  endfunction

  function automatic string vtag(input int i);
    case (i)
      0: return "R4"; 1: return "R5"; 2: return "R6"; 3: return "R3";
      4: return "R10"; 5: return "R5"; default: return "R9";
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int base, n0, tot, moved, bad, a;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state
    rd(3'd2, v); chk(v == 0, "R1", v, 0);
    rd(3'd0, v); chk(v == 0, "R1", v, 0);
    rd(3'd4, v); chk(v == 0, "R1", v, 0);
    chk(!irq_o && !mem_req_o, "R1", {irq_o, mem_req_o}, 0);
    // R2 map and readback
    wr(3'd4, 32'h0000_0103); rd(3'd4, v); chk(v == 32'h100, "R2", v, 32'h100);
    wr(3'd0, 32'h8); rd(3'd0, v); chk(v == 32'h8, "R2", v, 32'h8);
    rd(3'd2, v); chk(v == 0, "R2", v, 0);
    wr(3'd0, 32'h0);

    drv_en = 1'b1;
    for (int n = 0; n < NV; n++) begin
      setup(VECS[n].two, VECS[n].sz0, VECS[n].sz1);
      drv_bytes_i = VECS[n].nbytes;
      wr(3'd4, TBL);
      base = ack_seen;
      wr(3'd0, {28'd0, VECS[n].dir, 3'b001});
      wait_done(v);
      chk(v[2:0] == VECS[n].exp_st, vtag(n), v, VECS[n].exp_st);
      chk(irq_o == VECS[n].exp_st[2], "R4", irq_o, VECS[n].exp_st[2]);
      n0 = (VECS[n].sz0 == 0) ? 65536 : int'(VECS[n].sz0);
      tot = n0 + (VECS[n].two ? int'(VECS[n].sz1) : 0);
      moved = ((int'(VECS[n].nbytes) < tot) ? int'(VECS[n].nbytes) : tot) / 2;
      chk(ack_seen - base == moved, vtag(n), ack_seen - base, moved);
      bad = 0;
      for (int k = 0; k < moved; k++) begin
        a = (2*k < n0) ? BUF0 + 2*k : BUF1 + 2*k - n0;
        if (VECS[n].dir) begin
          if (mhalf(a) != (16'h5A00 ^ 16'(base + k))) bad++;
        end else begin
          if (cap_q[(base + k) % 4096] != (16'(a) ^ 16'h3C3C)) bad++;
        end
      end
      chk(bad == 0, "R9", bad, 0);
      wr(3'd0, 32'h0);
      rd(3'd2, v);
      chk(v[2:0] == (VECS[n].exp_st & 3'h6), "R7", v, VECS[n].exp_st & 3'h6);
      wr(3'd2, 32'h0); rd(3'd2, v);
      chk(v[2:0] == (VECS[n].exp_st & 3'h6), "R8", v, VECS[n].exp_st & 3'h6);
      wr(3'd2, 32'h6); rd(3'd2, v); chk(v == 0, "R8", v, 0);
    end

    // R7 cancel a stalled long transfer
    drv_en = 1'b0;
    setup(1'b0, 16'h1000, 16'h0);
    drv_bytes_i = 20'd512;
    wr(3'd4, TBL);
    wr(3'd0, 32'h9);
    repeat (30) @(negedge clk_i);
    rd(3'd2, v); chk(v == 32'h1, "R7", v, 1);
    base = ack_seen;
    wr(3'd0, 32'h0);
    rd(3'd2, v); chk(v == 32'h4, "R7", v, 4);
    drv_en = 1'b1;
    repeat (30) @(negedge clk_i);
    chk(ack_seen == base, "R7", ack_seen - base, 0);
    wr(3'd2, 32'h4);

    // R11 memory fault on size fetch
    setup(1'b0, 16'h0200, 16'h0);
    err_addr = TBL + 4;
    wr(3'd4, TBL);
    base = ack_seen;
    wr(3'd0, 32'h9);
    wait_done(v);
    chk(v == 32'h6, "R11", v, 6);
    chk(irq_o == 1'b1, "R11", irq_o, 1);
    chk(ack_seen == base, "R11", ack_seen - base, 0);
    err_addr = 32'hFFFF_FFFF;
    wr(3'd0, 32'h0);
    wr(3'd2, 32'h2); rd(3'd2, v); chk(v == 32'h4, "R8", v, 4);
    wr(3'd2, 32'h4); rd(3'd2, v); chk(v == 0, "R8", v, 0);

    // R12 request hold observed at the port
    chk(hold_viol == 0, "R12", hold_viol, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule